// File: doc/BRIEF.md
# Octant-Folded Twiddle Coefficient Generator

This block feeds the complex multiplier of one stage in a single-path delay-feedback FFT pipeline. Every clock it takes an exponent `k` and returns the twiddle W = e^(-j2πk/N) as two signed fixed-point words. `cos_o` carries the real part. `sin_o` carries the sine of the angle, which is the imaginary part negated. One new exponent is accepted on every cycle, and each result appears one clock after its exponent is captured.

A full table of N words is not stored. The coefficient table covers only the first eighth of the circle, from angle 0 up to and including π/4, which is N/8+1 entries. The table contents are computed when the design is elaborated. The three top bits of the folded exponent name the octant. A fold stage mirrors the offset in odd octants. An unfold stage then swaps and negates the two table outputs to recover the true coefficient. Exponent bits above log2(N) are accepted and have no effect, so any two exponents that are equal modulo N produce the same coefficient.

Top module: `twd_gen`

## Requirements
- R1: While `rst_ni` is low, `cos_o` and `sin_o` are both 0.
- R2: The outputs are registered, with a latency of exactly one cycle. A change on `k_i` does not reach the outputs before the next rising clock edge. After that edge the outputs correspond to the exponent sampled at it.
- R3: With S = 2^(COEF_W-1)-1 and θ = 2π·(k mod N)/N:
  - `cos_o` equals round(S·cos θ).
  - `sin_o` equals round(S·sin θ).
  - Rounding is half away from zero.
  - Both outputs are COEF_W-bit two's complement.
  - `sin_o` is the negated imaginary part of W = e^(-jθ).
- R4: In octant 0 (k mod N below N/8), the outputs are the table entries at the offset `k mod N/8`, passed through without change.
- R5: In the odd octants (1, 3, 5, 7), the table is addressed with N/8 minus the offset. At offset 0 of an odd octant this selects entry N/8, the point at π/4. The table address never exceeds N/8.
- R6: In octants 1, 2, 5 and 6, the roles of the table's cosine and sine words are exchanged.
- R7: The cosine output is negated in octants 2 through 5. The sine output is negated in octants 4 through 7.
- R8: Bits of `k_i` above bit log2(N)-1 have no effect on the outputs.
- R9: The four axis exponents give exact values:
  - 0 gives (S, 0).
  - N/4 gives (0, S).
  - N/2 gives (-S, 0).
  - 3N/4 gives (0, -S).
- R10: A distinct exponent can be presented on every cycle. Each one yields its own correct coefficient in the next cycle, with no stall or bubble.
- R11: Neither output ever takes the value -2^(COEF_W-1). Every output magnitude is at most S, and the sum of the squares of the two outputs stays within 2·S of S².

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| k_i | input | log2(N_PTS)+EXT_BITS | Twiddle exponent; bits above log2(N_PTS) are ignored |
| cos_o | output | COEF_W | Registered cosine part, signed |
| sin_o | output | COEF_W | Registered sine part (negated imaginary), signed |

## Verification
The bench builds two instances, one with N_PTS = 64 and EXT_BITS = 2, and one with N_PTS = 8 and EXT_BITS = 1. Both use 12-bit coefficients.

The 64-point instance has eight table offsets per octant. A full back-to-back sweep of that instance therefore reaches every fold, swap and negate case, every mirrored address including the π/4 entry, and all four axis points. Its two extra exponent bits make aliases at +N, +2N and +3N reachable.

The 8-point instance is the smallest legal size. Its offset field is empty and its table has just two entries, so every octant is a boundary case.

// File: rtl/twd_gen_pkg.sv
package twd_gen_pkg;

  localparam real PI = 3.14159265358979323846;

  typedef struct packed {
    logic swap;
    logic neg_re;
    logic neg_im;
  } unfold_ctl_t;

  // round half away from zero
  function automatic int coef_round(real x);
    if (x >= 0.0) return $rtoi(x + 0.5);
    return -$rtoi(0.5 - x);
  endfunction

  function automatic int tab_cos(int idx, int n_pts, int scale);
    return coef_round(real'(scale) * $cos(2.0 * PI * real'(idx) / real'(n_pts)));
  endfunction

  function automatic int tab_sin(int idx, int n_pts, int scale);
    return coef_round(real'(scale) * $sin(2.0 * PI * real'(idx) / real'(n_pts)));
  endfunction

endpackage

// File: rtl/twd_fold.sv
module twd_fold
  import twd_gen_pkg::*;
#(
  parameter int N_PTS = 4096,
  localparam int LOG2N = $clog2(N_PTS),
  localparam int OFF_W = LOG2N - 3,
  localparam int AW    = LOG2N - 2
) (
  input  logic [LOG2N-1:0] k_i,
  output logic [AW-1:0]    addr_o,
  output unfold_ctl_t      ctl_o
);

  localparam int OCT_SZ = N_PTS / 8;
  localparam logic [AW-1:0] MID = AW'(OCT_SZ);

  logic [2:0] oct;
  assign oct = k_i[LOG2N-1 -: 3];

  generate
    if (OFF_W == 0) begin : g_no_off
      // one offset per octant: mirror selects entry 0 or the pi/4 entry
      assign addr_o = AW'(oct[0]);
    end else begin : g_off
      logic [AW-1:0] off_ext;
      assign off_ext = {1'b0, k_i[OFF_W-1:0]};
      assign addr_o  = oct[0] ? (MID - off_ext) : off_ext;
    end
  endgenerate

  always_comb begin
    ctl_o.swap   = oct[0] ^ oct[1];
    ctl_o.neg_re = oct[2] ^ oct[1];
    ctl_o.neg_im = oct[2];
  end

endmodule

// File: rtl/twd_rom.sv
module twd_rom
  import twd_gen_pkg::*;
#(
  parameter int N_PTS  = 4096,
  parameter int COEF_W = 12,
  localparam int LOG2N = $clog2(N_PTS),
  localparam int AW    = LOG2N - 2,
  localparam int ENT   = N_PTS / 8 + 1,
  localparam int SCALE = 2 ** (COEF_W - 1) - 1
) (
  input  logic [AW-1:0]            addr_i,
  output logic signed [COEF_W-1:0] re_o,
  output logic signed [COEF_W-1:0] im_o
);

  logic signed [COEF_W-1:0] cos_tab [ENT];
  logic signed [COEF_W-1:0] sin_tab [ENT];

  generate
    for (genvar i = 0; i < ENT; i++) begin : g_ent
      localparam int CV = tab_cos(i, N_PTS, SCALE);
      localparam int SV = tab_sin(i, N_PTS, SCALE);
      assign cos_tab[i] = CV[COEF_W-1:0];
      assign sin_tab[i] = SV[COEF_W-1:0];
    end
  endgenerate

  assign re_o = cos_tab[addr_i];
  assign im_o = sin_tab[addr_i];

endmodule

// File: rtl/twd_unfold.sv
module twd_unfold
  import twd_gen_pkg::*;
#(
  parameter int COEF_W = 12
) (
  input  unfold_ctl_t              ctl_i,
  input  logic signed [COEF_W-1:0] a_i,
  input  logic signed [COEF_W-1:0] b_i,
  output logic signed [COEF_W-1:0] cos_o,
  output logic signed [COEF_W-1:0] sin_o
);

  logic signed [COEF_W-1:0] p, q;

  always_comb begin
    p = ctl_i.swap ? b_i : a_i;
    q = ctl_i.swap ? a_i : b_i;
    // table never holds the most negative code, negation cannot overflow
    cos_o = ctl_i.neg_re ? -p : p;
    sin_o = ctl_i.neg_im ? -q : q;
  end

endmodule

// File: rtl/twd_gen.sv
module twd_gen
  import twd_gen_pkg::*;
#(
  parameter int N_PTS    = 4096,
  parameter int EXT_BITS = 1,
  parameter int COEF_W   = 12,
  localparam int LOG2N   = $clog2(N_PTS),
  localparam int KW      = LOG2N + EXT_BITS,
  localparam int AW      = LOG2N - 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [KW-1:0]            k_i,
  output logic signed [COEF_W-1:0] cos_o,
  output logic signed [COEF_W-1:0] sin_o
);

  logic [AW-1:0]            rom_addr;
  unfold_ctl_t              ctl;
  logic signed [COEF_W-1:0] rom_re, rom_im;
  logic signed [COEF_W-1:0] cos_d, sin_d;
  logic                     unused_hi;

  // exponent is taken modulo N
  assign unused_hi = ^k_i[KW-1:LOG2N];

  twd_fold #(.N_PTS(N_PTS)) fold_i (
    .k_i    (k_i[LOG2N-1:0]),
    .addr_o (rom_addr),
    .ctl_o  (ctl)
  );

  twd_rom #(.N_PTS(N_PTS), .COEF_W(COEF_W)) rom_i (
    .addr_i (rom_addr),
    .re_o   (rom_re),
    .im_o   (rom_im)
  );

  twd_unfold #(.COEF_W(COEF_W)) unfold_i (
    .ctl_i (ctl),
    .a_i   (rom_re),
    .b_i   (rom_im),
    .cos_o (cos_d),
    .sin_o (sin_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cos_o <= '0;
      sin_o <= '0;
    end else begin
      cos_o <= cos_d;
      sin_o <= sin_d;
    end
  end

endmodule

// File: rtl/twd_gen_chk.sv
module twd_gen_chk #(
  parameter int N_PTS    = 4096,
  parameter int EXT_BITS = 1,
  parameter int COEF_W   = 12,
  localparam int LOG2N   = $clog2(N_PTS),
  localparam int KW      = LOG2N + EXT_BITS,
  localparam int AW      = LOG2N - 2,
  localparam int SCALE   = 2 ** (COEF_W - 1) - 1
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [KW-1:0]            k_i,
  input logic signed [COEF_W-1:0] cos_o,
  input logic signed [COEF_W-1:0] sin_o,
  input logic [AW-1:0]            rom_addr
);

  localparam logic [LOG2N-1:0] K_HALF = LOG2N'(N_PTS / 2);
  localparam logic [LOG2N-1:0] K_QTR  = LOG2N'(N_PTS / 4);

  logic run_q;
  int   mag2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= 1'b1;
  end

  assign mag2 = int'(cos_o) * int'(cos_o) + int'(sin_o) * int'(sin_o);

  // R5
  rom_addr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(rom_addr) <= N_PTS / 8);

  // R9
  axis_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (k_i[LOG2N-1:0] == '0) |=> (int'(cos_o) == SCALE && sin_o == '0));

  // R9
  axis_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (k_i[LOG2N-1:0] == K_HALF) |=> (int'(cos_o) == -SCALE && sin_o == '0));

  // R9
  axis_qtr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (k_i[LOG2N-1:0] == K_QTR) |=> (cos_o == '0 && int'(sin_o) == SCALE));

  // R8
  alias_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && k_i[LOG2N-1:0] == $past(k_i[LOG2N-1:0])) |=> $stable({cos_o, sin_o}));

  // R11
  no_min_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(cos_o) >= -SCALE && int'(sin_o) >= -SCALE));

  // R11
  unit_mag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (mag2 <= SCALE * SCALE + 2 * SCALE && mag2 >= SCALE * SCALE - 2 * SCALE));

endmodule

bind twd_gen twd_gen_chk #(
  .N_PTS(N_PTS), .EXT_BITS(EXT_BITS), .COEF_W(COEF_W)
) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .k_i      (k_i),
  .cos_o    (cos_o),
  .sin_o    (sin_o),
  .rom_addr (rom_addr)
);

// File: tb/twd_gen_tb_top.sv
module twd_gen_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NB   = 64;
  localparam int NS   = 8;
  localparam int KWB  = 6 + 2;
  localparam int KWS  = 3 + 1;
  localparam int SC   = 2047;
  localparam real PI_TB = 3.14159265358979323846;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [KWB-1:0] k_big = '0;
  logic [KWS-1:0] k_small = '0;
  logic signed [11:0] cb, sb, cs, ss;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  twd_gen #(.N_PTS(NB), .EXT_BITS(2), .COEF_W(12)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .k_i(k_big), .cos_o(cb), .sin_o(sb));

  twd_gen #(.N_PTS(NS), .EXT_BITS(1), .COEF_W(12)) dut_small_i (
    .clk_i(clk), .rst_ni(rst_ni), .k_i(k_small), .cos_o(cs), .sin_o(ss));

  function automatic int rnd(real x);
    if (x >= 0.0) return $rtoi(x + 0.5);
    return -$rtoi(0.5 - x);
  endfunction

  function automatic int exp_c(int k, int n);
    return rnd(real'(SC) * $cos(2.0 * PI_TB * real'(k % n) / real'(n)));
  endfunction

  function automatic int exp_s(int k, int n);
    return rnd(real'(SC) * $sin(2.0 * PI_TB * real'(k % n) / real'(n)));
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_big(string req, int k);
    chk(req, $sformatf("cos k=%0d", k), int'(cb), exp_c(k, NB));
    chk(req, $sformatf("sin k=%0d", k), int'(sb), exp_s(k, NB));
  endtask

  task automatic one_big(string req, int k);
    @(negedge clk);
    k_big = KWB'(k);
    @(negedge clk);
    chk_big(req, k);
  endtask

  // R1
  task automatic t_reset();
    rst_ni = 1'b0;
    k_big = KWB'(5);
    k_small = KWS'(3);
    repeat (3) @(negedge clk);
    chk("R1", "cos reset", int'(cb), 0);
    chk("R1", "sin reset", int'(sb), 0);
    chk("R1", "small cos reset", int'(cs), 0);
    chk("R1", "small sin reset", int'(ss), 0);
    rst_ni = 1'b1;
  endtask

  // R2
  task automatic t_latency();
    one_big("R2", 0);
    @(negedge clk);
    k_big = KWB'(5);
    #1;
    chk("R2", "cos before edge", int'(cb), SC);
    chk("R2", "sin before edge", int'(sb), 0);
    @(negedge clk);
    chk_big("R2", 5);
  endtask

  // R4 R5 R6 R7
  task automatic t_octants();
    one_big("R4", 3);
    one_big("R4", 7);
    one_big("R5", 8);
    one_big("R5", 13);
    one_big("R5", 56);
    one_big("R6", 11);
    one_big("R6", 42);
    one_big("R7", 20);
    one_big("R7", 28);
    one_big("R7", 36);
    one_big("R7", 60);
  endtask

  // R9
  task automatic t_axes();
    @(negedge clk); k_big = KWB'(0);
    @(negedge clk); chk("R9", "cos k=0", int'(cb), SC);   chk("R9", "sin k=0", int'(sb), 0);
    k_big = KWB'(16);
    @(negedge clk); chk("R9", "cos k=16", int'(cb), 0);   chk("R9", "sin k=16", int'(sb), SC);
    k_big = KWB'(32);
    @(negedge clk); chk("R9", "cos k=32", int'(cb), -SC); chk("R9", "sin k=32", int'(sb), 0);
    k_big = KWB'(48);
    @(negedge clk); chk("R9", "cos k=48", int'(cb), 0);   chk("R9", "sin k=48", int'(sb), -SC);
  endtask

  // R3 R10 R11: back-to-back sweep of every exponent
  task automatic t_sweep();
    int prev = 0;
    for (int i = 0; i <= NB; i++) begin
      @(negedge clk);
      if (i > 0) begin
        chk_big("R3", prev);
        chk("R10", "stream cos", int'(cb), exp_c(prev, NB));
        checks++;
        if (int'(cb) < -SC || int'(sb) < -SC) begin
          errors++;
          $display("FAIL R11 min code k=%0d: actual %0d/%0d expected >= %0d", prev, cb, sb, -SC);
        end
      end
      if (i < NB) begin
        prev = (i * 37) % NB;
        k_big = KWB'(prev);
      end
    end
  endtask

  // R8
  task automatic t_alias();
    for (int a = 1; a < 4; a++) begin
      one_big("R8", 9 + a * NB);
      chk("R8", "alias cos", int'(cb), exp_c(9, NB));
      one_big("R8", 50 + a * NB);
      chk("R8", "alias sin", int'(sb), exp_s(50, NB));
    end
  endtask

  // R3 R8 on the smallest size
  task automatic t_small();
    for (int i = 0; i < 2 * NS; i++) begin
      @(negedge clk);
      k_small = KWS'(i);
      @(negedge clk);
      chk((i >= NS) ? "R8" : "R3", $sformatf("small cos k=%0d", i), int'(cs), exp_c(i, NS));
      chk((i >= NS) ? "R8" : "R3", $sformatf("small sin k=%0d", i), int'(ss), exp_s(i, NS));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_latency();
    t_octants();
    t_axes();
    t_sweep();
    t_alias();
    t_small();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule